// File: doc/BRIEF.md
# Linked-Channel Update Controller

This block coordinates a group of PWM channels that run in lockstep. It holds which channels belong to the group, an update mode, an update-period value with a shadow copy, and a pending-unlock flag that clears itself. Every time the reference channel (channel 0) ends a period, the block decides which buffered parameters the linked channels copy into their active registers: period, dead-time and duty. It shows that decision as one-cycle commit strobes, one bit per channel for each parameter class.

In manual mode, software sets the unlock flag and all three classes commit at the next period end. In the two automatic modes the unlock flag commits only period and dead-time. Duty then commits by itself once every (update period + 1) reference periods, timed by an internal down-counter. In the request-driven automatic mode, a ready flag tells an external transfer engine that the next duty value can be supplied. The engine acknowledges each delivery.

Top module: `sync_update_ctrl`

## Requirements
- R1: After a synchronous reset, the outputs are as follows. All commit strobes are 0. The unlock flag is 0. The active update period and the counter are 0. The request flag is 0. The link mask holds only channel 0.
- R2: A configuration write stores the link mask and the mode. Bit 0 of the stored mask is always 1, whatever value is written. Mode encoding: 0 is manual, 1 is automatic, 2 is automatic with transfer request, and 3 acts as manual.
- R3: An unlock write sets the pending flag in the next cycle. The flag stays set until the first period end it sees, and it clears after that period end unless another unlock write arrives in the same cycle.
- R4: In manual mode, a period end with the pending flag set makes the period, dead-time and duty strobes equal the link mask for exactly the following cycle.
- R5: In automatic modes, a period end with the pending flag set makes only the period and dead-time strobes equal the link mask in the following cycle. The unlock does not produce a duty strobe.
- R6: An update-period write while channel 0 is disabled loads the active value and the counter directly. While channel 0 is enabled, the write goes only to the shadow copy, and the active value and the counter do not change.
- R7: On each period end, a non-zero counter decrements. A zero counter reloads instead. If the shadow copy is pending, the reload takes the shadow value, which also becomes the active value. Otherwise the reload takes the active value.
- R8: In automatic modes, a period end that finds the counter at 0 makes the duty strobe equal the link mask in the following cycle. Duty therefore commits once every (update period + 1) period ends.
- R9: The request flag is set by an automatic duty commit in mode 2 and cleared by an acknowledge. When both happen in the same cycle, the set wins. A configuration write that selects any mode other than 2 clears the flag, and this takes priority over the set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_link | input | N_CH | Requested link mask (bit 0 ignored) |
| cfg_mode | input | 2 | Requested update mode |
| unlock_wr | input | 1 | Unlock write strobe |
| upr_we | input | 1 | Update-period write strobe |
| upr_val | input | UPR_W | Update-period write value |
| ch0_en | input | 1 | Channel 0 is enabled |
| per_end | input | 1 | One-cycle pulse at the end of a channel 0 period |
| dma_ack | input | 1 | Transfer engine delivered a duty value |
| link_mask | output | N_CH | Current link mask |
| commit_prd | output | N_CH | Per-channel period commit strobe |
| commit_dt | output | N_CH | Per-channel dead-time commit strobe |
| commit_dty | output | N_CH | Per-channel duty commit strobe |
| unlock_pend | output | 1 | Unlock pending flag |
| upr_act | output | UPR_W | Active update period |
| upr_cnt | output | UPR_W | Update-period down-counter |
| dma_req | output | 1 | Ready for the next duty value |

## Verification
The bench builds the block with four channels and a 3-bit update period. With these values the counter wraps within at most eight period ends, so random traffic reaches many reloads, shadow hand-overs and duty commits. Period ends are dense and all modes, including the reserved code, are drawn at random. This puts unlock writes, shadow writes, acknowledges and mode changes into the same cycle as period ends and counter wraps.

// File: rtl/sync_update_pkg.sv
`timescale 1ns/1ps
// Shared types for the linked-channel update controller.
// Assumes: mode code 3 is reserved and is treated as manual.
package sync_update_pkg;
    typedef enum logic [1:0] {
        UPD_MANUAL   = 2'd0,
        UPD_AUTO     = 2'd1,
        UPD_AUTO_REQ = 2'd2,
        UPD_RSVD     = 2'd3
    } upd_mode_e;

    // True when duty commits come from the counter and not from the unlock.
    function automatic logic is_auto(upd_mode_e m);
        return (m == UPD_AUTO) || (m == UPD_AUTO_REQ);
    endfunction
endpackage

// File: rtl/sync_upr_timer.sv
`timescale 1ns/1ps
// Update-period timer: holds the active update period, its shadow copy and the
// down-counter, and flags period ends at which the counter is at zero.
// Assumes: per_end is a one-cycle pulse. A direct write is legal only while
// channel 0 is disabled, and any other write goes to the shadow copy.
module sync_upr_timer #(
    parameter int UPR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ch0_en,
    input  logic             upr_we,
    input  logic [UPR_W-1:0] upr_val,
    input  logic             per_end,
    output logic             wrap_evt,
    output logic [UPR_W-1:0] upr_act,
    output logic [UPR_W-1:0] upr_cnt
);
    logic [UPR_W-1:0] shd_q;
    logic             shd_vld_q;
    logic             direct_wr;

    assign direct_wr = upr_we && !ch0_en;
    assign wrap_evt  = per_end && (upr_cnt == '0);

    // Counter, active value and shadow hand-over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upr_act   <= '0;
            upr_cnt   <= '0;
            shd_q     <= '0;
            shd_vld_q <= 1'b0;
        end else if (direct_wr) begin
            upr_act   <= upr_val;
            upr_cnt   <= upr_val;
            shd_vld_q <= 1'b0;
        end else begin
            if (per_end) begin
                if (upr_cnt != '0) begin
                    upr_cnt <= upr_cnt - UPR_W'(1);
                end else if (shd_vld_q) begin
                    upr_act   <= shd_q;
                    upr_cnt   <= shd_q;
                    shd_vld_q <= 1'b0;
                end else begin
                    upr_cnt <= upr_act;
                end
            end
            if (upr_we) begin
                shd_q     <= upr_val;
                shd_vld_q <= 1'b1;
            end
        end
    end

    // R7: a non-zero counter steps down by one at a period end
    assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (per_end && upr_cnt != '0 && !direct_wr) |=> (upr_cnt == UPR_W'($past(upr_cnt) - UPR_W'(1))));
    // R7: the counter never exceeds the active period
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        upr_cnt <= upr_act);
    // R6: a shadow write leaves the active value untouched unless a wrap hands it over
    assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upr_we && ch0_en && !wrap_evt) |=> $stable(upr_act));
endmodule

// File: rtl/sync_unlock_ctrl.sv
`timescale 1ns/1ps
// Unlock flag: set by a write, consumed by the next period end.
// Assumes: a write in the same cycle as the consuming period end re-arms the flag.
module sync_unlock_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic unlock_wr,
    input  logic per_end,
    output logic commit_evt,
    output logic pend
);
    assign commit_evt = per_end && pend;

    // Pending flag with self-clear at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= unlock_wr || (pend && !per_end);
    end

    // R3: a write always arms the flag
    assert_unlock_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_wr |=> pend);
    // R3: the flag is consumed by its period end
    assert_unlock_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (per_end && pend && !unlock_wr) |=> !pend);
endmodule

// File: rtl/sync_req_flag.sv
`timescale 1ns/1ps
// Transfer-request ready flag for the request-driven automatic mode.
// Assumes priority: clear by mode change, then set, then acknowledge.
module sync_req_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set,
    input  logic ack,
    output logic req
);
    // Flag update by priority.
    always_ff @(posedge clk) begin
        if (!rst_n)   req <= 1'b0;
        else if (clr) req <= 1'b0;
        else if (set) req <= 1'b1;
        else if (ack) req <= 1'b0;
    end

    // R9: an acknowledge with no competing set drops the flag
    assert_ack_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !set) |=> !req);
    // R9: a set with no mode-change clear raises the flag
    assert_set_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set && !clr) |=> req);
endmodule

// File: rtl/sync_update_ctrl.sv
`timescale 1ns/1ps
// Linked-channel update controller (top). It holds the link mask and the mode,
// and it turns unlock and counter-wrap events at channel 0 period ends into
// registered per-channel commit strobes for period, dead-time and duty.
// Assumes: channel 0 is the timing reference and always belongs to the group.
module sync_update_ctrl
    import sync_update_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int UPR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [N_CH-1:0]  cfg_link,
    input  logic [1:0]       cfg_mode,
    input  logic             unlock_wr,
    input  logic             upr_we,
    input  logic [UPR_W-1:0] upr_val,
    input  logic             ch0_en,
    input  logic             per_end,
    input  logic             dma_ack,
    output logic [N_CH-1:0]  link_mask,
    output logic [N_CH-1:0]  commit_prd,
    output logic [N_CH-1:0]  commit_dt,
    output logic [N_CH-1:0]  commit_dty,
    output logic             unlock_pend,
    output logic [UPR_W-1:0] upr_act,
    output logic [UPR_W-1:0] upr_cnt,
    output logic             dma_req
);
    upd_mode_e mode_q;
    logic      wrap_evt, unlock_evt, auto_m, dty_evt, req_set, req_clr;

    assign auto_m  = is_auto(mode_q);
    assign dty_evt = (unlock_evt && !auto_m) || (wrap_evt && auto_m);
    assign req_set = wrap_evt && (mode_q == UPD_AUTO_REQ);
    assign req_clr = cfg_we && (upd_mode_e'(cfg_mode) != UPD_AUTO_REQ);

    // Configuration registers; channel 0 is forced into the group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_mask <= N_CH'(1);
            mode_q    <= UPD_MANUAL;
        end else if (cfg_we) begin
            link_mask <= cfg_link | N_CH'(1);
            mode_q    <= upd_mode_e'(cfg_mode);
        end
    end

    // One strobe register per channel and parameter class.
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                commit_prd[c] <= 1'b0;
                commit_dt[c]  <= 1'b0;
                commit_dty[c] <= 1'b0;
            end else begin
                commit_prd[c] <= unlock_evt && link_mask[c];
                commit_dt[c]  <= unlock_evt && link_mask[c];
                commit_dty[c] <= dty_evt && link_mask[c];
            end
        end
    end

    sync_upr_timer #(.UPR_W(UPR_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .ch0_en(ch0_en), .upr_we(upr_we),
        .upr_val(upr_val), .per_end(per_end), .wrap_evt(wrap_evt),
        .upr_act(upr_act), .upr_cnt(upr_cnt)
    );

    sync_unlock_ctrl unlock_i (
        .clk(clk), .rst_n(rst_n), .unlock_wr(unlock_wr), .per_end(per_end),
        .commit_evt(unlock_evt), .pend(unlock_pend)
    );

    sync_req_flag req_i (
        .clk(clk), .rst_n(rst_n), .clr(req_clr), .set(req_set),
        .ack(dma_ack), .req(dma_req)
    );

    // R2: channel 0 is in the group after every configuration write
    assert_ch0_linked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> link_mask[0]);
    // R5: in an automatic mode, an unlock alone never commits duty
    assert_no_unlock_duty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock_evt && auto_m && !wrap_evt) |=> (commit_dty == '0));
    // R4: strobes stay inside the group that was linked at the period end
    assert_strobe_in_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((commit_prd | commit_dty) != '0) |-> (((commit_prd | commit_dty) & ~$past(link_mask)) == '0));
endmodule

// File: tb/sync_update_ctrl_tb_top.sv
`timescale 1ns/1ps
module sync_update_ctrl_tb_top;
    localparam int N = 4;
    localparam int W = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 0, unlock_wr = 0, upr_we = 0, ch0_en = 0, per_end = 0, dma_ack = 0;
    logic [N-1:0] cfg_link = '0;
    logic [1:0]   cfg_mode = '0;
    logic [W-1:0] upr_val = '0;
    logic [N-1:0] link_mask, commit_prd, commit_dt, commit_dty;
    logic         unlock_pend, dma_req;
    logic [W-1:0] upr_act, upr_cnt;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // Expected state
    logic [N-1:0] m_mask, m_prd, m_dt, m_dty;
    logic [1:0]   m_mode;
    logic         m_pend, m_req, m_shv;
    logic [W-1:0] m_act, m_cnt, m_shd;

    always #5 clk = ~clk;

    sync_update_ctrl #(.N_CH(N), .UPR_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_link(cfg_link),
        .cfg_mode(cfg_mode), .unlock_wr(unlock_wr), .upr_we(upr_we),
        .upr_val(upr_val), .ch0_en(ch0_en), .per_end(per_end), .dma_ack(dma_ack),
        .link_mask(link_mask), .commit_prd(commit_prd), .commit_dt(commit_dt),
        .commit_dty(commit_dty), .unlock_pend(unlock_pend), .upr_act(upr_act),
        .upr_cnt(upr_cnt), .dma_req(dma_req)
    );

    function automatic bit auto_mode(logic [1:0] m);
        return (m == 2'd1) || (m == 2'd2);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_mask = N'(1); m_mode = 0; m_pend = 0; m_req = 0; m_shv = 0;
        m_act = 0; m_cnt = 0; m_shd = 0; m_prd = 0; m_dt = 0; m_dty = 0;
    endtask

    // Advance the expected state by one clock, from the inputs currently driven.
    task automatic model_step();
        logic zero, uev, am;
        am   = auto_mode(m_mode);
        zero = per_end && (m_cnt == 0);
        uev  = per_end && m_pend;
        m_prd = uev ? m_mask : '0;                             // R4 R5
        m_dt  = uev ? m_mask : '0;
        m_dty = ((uev && !am) || (zero && am)) ? m_mask : '0;  // R4 R8
        if (cfg_we && cfg_mode != 2'd2) m_req = 0;             // R9
        else if (zero && m_mode == 2'd2) m_req = 1;
        else if (dma_ack) m_req = 0;
        m_pend = unlock_wr || (m_pend && !per_end);            // R3
        if (upr_we && !ch0_en) begin                           // R6
            m_act = upr_val; m_cnt = upr_val; m_shv = 0;
        end else begin
            if (per_end) begin                                 // R7
                if (m_cnt != 0) m_cnt = m_cnt - 1;
                else if (m_shv) begin m_act = m_shd; m_cnt = m_shd; m_shv = 0; end
                else m_cnt = m_act;
            end
            if (upr_we) begin m_shd = upr_val; m_shv = 1; end
        end
        if (cfg_we) begin m_mask = cfg_link | N'(1); m_mode = cfg_mode; end  // R2
    endtask

    task automatic compare();
        chk("R2 link_mask", 32'(link_mask), 32'(m_mask));
        chk("R3 unlock_pend", 32'(unlock_pend), 32'(m_pend));
        chk("R4,R5 commit_prd", 32'(commit_prd), 32'(m_prd));
        chk("R4,R5 commit_dt", 32'(commit_dt), 32'(m_dt));
        chk("R4,R8 commit_dty", 32'(commit_dty), 32'(m_dty));
        chk("R6,R7 upr_act", 32'(upr_act), 32'(m_act));
        chk("R7 upr_cnt", 32'(upr_cnt), 32'(m_cnt));
        chk("R9 dma_req", 32'(dma_req), 32'(m_req));
    endtask

    // One clock: inputs already driven, update model, sample at the falling edge.
    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        cfg_we = 0; unlock_wr = 0; upr_we = 0; per_end = 0; dma_ack = 0;
    endtask

    task automatic cfg(logic [N-1:0] l, logic [1:0] m);
        idle(); cfg_we = 1; cfg_link = l; cfg_mode = m; step(); idle();
    endtask

    task automatic pend(); idle(); per_end = 1; step(); idle(); step(); endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 commit_prd", 32'(commit_prd), 0);
        chk("R1 commit_dty", 32'(commit_dty), 0);
        chk("R1 link_mask", 32'(link_mask), 1);
        chk("R1 dma_req", 32'(dma_req), 0);
        chk("R1 upr_cnt", 32'(upr_cnt), 0);
        // R2: bit 0 forced even when written 0
        cfg(4'b1010, 2'd0);
        chk("R2 forced ch0", 32'(link_mask), 32'hB);
        // R4: manual unlock commits all three classes
        unlock_wr = 1; step(); idle();
        chk("R3 set", 32'(unlock_pend), 1);
        per_end = 1; step(); idle();
        chk("R4 dty on unlock", 32'(commit_dty), 32'hB);
        step();
        chk("R3 self clear", 32'(unlock_pend), 0);
        // R6: direct load while ch0 disabled, shadow while enabled
        upr_we = 1; upr_val = 3'd2; step(); idle();
        chk("R6 direct act", 32'(upr_act), 2);
        ch0_en = 1; upr_we = 1; upr_val = 3'd5; step(); idle();
        chk("R6 shadow hold", 32'(upr_act), 2);
        // R8: auto mode, duty at wrap; R5: unlock gives no duty
        cfg(4'b0110, 2'd2);
        unlock_wr = 1; step(); idle();
        pend(); pend();  // counter 2 -> 1 -> 0
        chk("R5 no dty", 32'(commit_dty), 0);
        per_end = 1; step(); idle();
        chk("R8 dty at wrap", 32'(commit_dty), 32'h7);
        chk("R7 shadow taken", 32'(upr_act), 5);
        chk("R9 req set", 32'(dma_req), 1);
        dma_ack = 1; step(); idle();
        chk("R9 ack clear", 32'(dma_req), 0);
        // Random traffic
        for (int i = 0; i < 6000; i++) begin
            cfg_we    = ($urandom % 40) == 0;
            cfg_link  = N'($urandom);
            cfg_mode  = 2'($urandom);
            unlock_wr = ($urandom % 6) == 0;
            upr_we    = ($urandom % 10) == 0;
            upr_val   = W'($urandom);
            ch0_en    = ($urandom % 4) != 0;
            per_end   = ($urandom % 3) == 0;
            dma_ack   = ($urandom % 4) == 0;
            step();
        end
        idle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule